// File: doc/BRIEF.md
# APB SPI Register and FIFO Front-End

This block is the bus-facing half of an SPI controller. It is an APB slave with no wait states. Software loads transmit bytes into a 16-entry TX FIFO through a data register. It drains received bytes from a 16-entry RX FIFO through a receive register. It also reads a packed status word that carries the full and empty flags, the engine busy flag, a sticky overflow bit and both FIFO fill levels.

A separate serial engine consumes the TX FIFO through a valid/pop handshake and fills the RX FIFO through a push strobe. The engine also reads the baud divider held here. The front-end does not shift serial data and does not time the chip select.

The block drives a level-sensitive interrupt. It is high while the TX FIFO is empty and interrupt enable bit 0 is set. Software clears it by writing data or by clearing the enable.

Top module: `spi_apb_front`

## Requirements
- R1: After synchronous reset with presetn low, both FIFOs are empty and all registers are zero. A status read returns 0x00000002, irq_o is 0, baud_div_o is 0 and eng_tx_valid is 0.
- R2: An APB write to offset 0x08 in the access phase (psel and penable high) pushes pwdata[7:0] into the TX FIFO. After that edge, eng_tx_data shows the byte and the TX level in the status word rises by one.
- R3: TX bytes leave in write order. A cycle with eng_tx_pop high while eng_tx_valid is high advances to the next byte.
- R4: Status bit 0 (TX full) is 1 exactly when the TX level reaches 16.
- R5: A write to offset 0x08 while the TX FIFO is full leaves the level at 16 and discards the byte. It also sets sticky status bit 3. Writing a 1 to bit 3 at offset 0x04 clears that bit.
- R6: A read of offset 0x0C returns the oldest received byte in prdata[7:0], with the upper bits zero. The byte is removed on the access edge.
- R7: A read of offset 0x0C while the RX FIFO is empty returns 0 and leaves the RX level unchanged.
- R8: The status word at offset 0x04 is laid out as follows: bit 0 TX full, bit 1 RX empty, bit 2 eng_busy, bit 3 overflow, bits 15:8 TX level, bits 23:16 RX level, all other bits 0.
- R9: irq_o is 1 when the TX FIFO is empty and bit 0 of the enable register at offset 0x10 is set. It drops after the edge that accepts a TX write, or the edge that clears the enable. The enable bit reads back at offset 0x10.
- R10: A write to offset 0x14 loads pwdata[15:0] into the baud divider. The value drives baud_div_o and reads back at 0x14.
- R11: pready is always 1 and pslverr is always 0.
- R12: An eng_rx_push while the RX FIFO holds 16 bytes is discarded. The 16 stored bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always 0 |
| irq_o | output | 1 | Level interrupt, TX empty and enabled |
| baud_div_o | output | 16 | Baud divider to engine |
| eng_tx_valid | output | 1 | TX FIFO holds a byte |
| eng_tx_data | output | 8 | Oldest TX byte |
| eng_tx_pop | input | 1 | Engine takes the TX byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_busy | input | 1 | Engine busy flag for status |

## Verification
The hardest state to reach is overflow. It needs a TX FIFO filled to exactly 16 while nothing drains it, followed by one more write. The bench holds eng_tx_pop low and issues sixteen data writes, then a seventeenth. It then drains all sixteen entries to prove the extra byte never entered. RX saturation is reached the same way by pushing seventeen bytes from the engine side before any bus read.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;
    // Register byte offsets
    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam logic [7:0] OFS_TXDATA = 8'h08;
    localparam logic [7:0] OFS_RXDATA = 8'h0C;
    localparam logic [7:0] OFS_IEN    = 8'h10;
    localparam logic [7:0] OFS_BAUD   = 8'h14;

    // Status word bit positions
    localparam int ST_TXFULL  = 0;
    localparam int ST_RXEMPTY = 1;
    localparam int ST_BUSY    = 2;
    localparam int ST_OVF     = 3;
    localparam int ST_TXLVL   = 8;
    localparam int ST_RXLVL   = 16;

    typedef struct packed {
        logic       tx_full;
        logic       rx_empty;
        logic       busy;
        logic       ovf;
        logic [7:0] tx_lvl;
        logic [7:0] rx_lvl;
    } status_t;

    // Packs the status fields into the bus word
    function automatic logic [31:0] pack_status(input status_t s);
        logic [31:0] w;
        w = '0;
        w[ST_TXFULL]           = s.tx_full;
        w[ST_RXEMPTY]          = s.rx_empty;
        w[ST_BUSY]             = s.busy;
        w[ST_OVF]              = s.ovf;
        w[ST_TXLVL +: 8]       = s.tx_lvl;
        w[ST_RXLVL +: 8]       = s.rx_lvl;
        return w;
    endfunction
endpackage

// File: rtl/spi_front_fifo.sv
// Synchronous FIFO with a level counter.
// A push is accepted only when the FIFO is not full, and a pop only when it is not empty.
// The head entry is presented combinationally on rdata.
// Assumes a single clock and a synchronous active-low reset.
module spi_front_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [W-1:0]                  wdata,
    input  logic                          pop,
    output logic [W-1:0]                  rdata,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic                          full,
    output logic                          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];
    assign level   = cnt;

    // Next pointer with wrap for any depth
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    // Store accepted push data
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LW'(DEPTH));
    a_r12_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(wp)));
    a_r7_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && $stable(rp)));
endmodule

// File: rtl/spi_front_ctl.sv
// Control registers: interrupt enable, baud divider and the sticky overflow flag.
// Also drives the level interrupt.
// Assumes the write strobes are single-cycle APB access-phase pulses.
module spi_front_ctl #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ien,
    input  logic              wr_baud,
    input  logic              wr_status,
    input  logic [31:0]       wdata,
    input  logic              tx_write,
    input  logic              tx_full,
    input  logic              tx_empty,
    output logic              ien,
    output logic [BAUD_W-1:0] baud,
    output logic              ovf,
    output logic              irq
);
    logic unused_bits;
    logic clr_ovf;

    assign unused_bits = ^wdata;
    assign clr_ovf     = wr_status && wdata[spi_front_pkg::ST_OVF];
    assign irq         = ien && tx_empty;

    // Enable and divider registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien  <= 1'b0;
            baud <= '0;
        end else begin
            if (wr_ien)  ien  <= wdata[0];
            if (wr_baud) baud <= wdata[BAUD_W-1:0];
        end
    end

    // Sticky overflow: set on a write into a full TX FIFO, cleared by writing 1
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf <= 1'b0;
        else if (tx_write && tx_full) ovf <= 1'b1;
        else if (clr_ovf)            ovf <= 1'b0;
    end

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf);
    a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_write && tx_full) |=> ovf);
    a_r10_baud_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_baud |=> (baud == $past(wdata[BAUD_W-1:0])));
endmodule

// File: rtl/spi_apb_front.sv
// APB slave front-end for an SPI engine.
// Decodes zero-wait-state register accesses, owns the TX and RX FIFOs, packs the
// status word and exposes FIFO handshakes plus the baud divider to the engine.
// Assumes the engine pops only while eng_tx_valid is high.
module spi_apb_front #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int BAUD_W  = 16
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq_o,
    output logic [BAUD_W-1:0] baud_div_o,
    output logic              eng_tx_valid,
    output logic [DATA_W-1:0] eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_busy
);
    import spi_front_pkg::*;

    localparam int LW = $clog2(DEPTH+1);

    logic              acc, wr, rd;
    logic              wr_tx, rd_rx, wr_ien, wr_baud, wr_status;
    logic [LW-1:0]     tx_lvl, rx_lvl;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              ien, ovf;
    status_t           st;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // Access-phase decode
    assign acc       = psel && penable;
    assign wr        = acc && pwrite;
    assign rd        = acc && !pwrite;
    assign wr_tx     = wr && (paddr == ADDR_W'(OFS_TXDATA));
    assign wr_status = wr && (paddr == ADDR_W'(OFS_STATUS));
    assign wr_ien    = wr && (paddr == ADDR_W'(OFS_IEN));
    assign wr_baud   = wr && (paddr == ADDR_W'(OFS_BAUD));
    assign rd_rx     = rd && (paddr == ADDR_W'(OFS_RXDATA));

    spi_front_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(pclk), .rst_n(presetn),
        .push(wr_tx), .wdata(pwdata[DATA_W-1:0]),
        .pop(eng_tx_pop), .rdata(eng_tx_data),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    spi_front_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(pclk), .rst_n(presetn),
        .push(eng_rx_push), .wdata(eng_rx_data),
        .pop(rd_rx), .rdata(rx_head),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    spi_front_ctl #(.BAUD_W(BAUD_W)) u_ctl (
        .clk(pclk), .rst_n(presetn),
        .wr_ien(wr_ien), .wr_baud(wr_baud), .wr_status(wr_status),
        .wdata(pwdata), .tx_write(wr_tx),
        .tx_full(tx_full), .tx_empty(tx_empty),
        .ien(ien), .baud(baud_div_o), .ovf(ovf), .irq(irq_o)
    );

    assign eng_tx_valid = !tx_empty;

    // Gather status fields
    always_comb begin
        st.tx_full  = tx_full;
        st.rx_empty = rx_empty;
        st.busy     = eng_busy;
        st.ovf      = ovf;
        st.tx_lvl   = 8'(tx_lvl);
        st.rx_lvl   = 8'(rx_lvl);
    end

    // Read data mux
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                ADDR_W'(OFS_STATUS): prdata = pack_status(st);
                ADDR_W'(OFS_RXDATA): prdata = rx_empty ? 32'h0 : 32'(rx_head);
                ADDR_W'(OFS_IEN):    prdata = 32'(ien);
                ADDR_W'(OFS_BAUD):   prdata = 32'(baud_div_o);
                default:             prdata = '0;
            endcase
        end
    end

    a_r9_irq_falls_on_write: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_tx && irq_o) |=> !irq_o);
    a_r6_rx_pop_level: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_rx && !rx_empty && !eng_rx_push) |=> (rx_lvl == $past(rx_lvl) - 1'b1));
    a_r12_rx_full_hold: assert property (@(posedge pclk) disable iff (!presetn)
        (rx_full && eng_rx_push && !rd_rx) |=> rx_full);
endmodule

// File: tb/spi_apb_front_test.sv
module spi_apb_front_test;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq_o;
    logic [15:0] baud_div_o;
    logic        eng_tx_valid;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0, eng_busy = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] rv;

    always #10 pclk = ~pclk;

    spi_apb_front uut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .irq_o(irq_o),
        .baud_div_o(baud_div_o), .eng_tx_valid(eng_tx_valid),
        .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_busy(eng_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge pclk); penable = 1; #2; d = prdata;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic eng_pop();
        @(negedge pclk); eng_tx_pop = 1;
        @(negedge pclk); eng_tx_pop = 0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge pclk); eng_rx_push = 1; eng_rx_data = b;
        @(negedge pclk); eng_rx_push = 0;
    endtask

    task automatic t_reset();
        apb_read(8'h04, rv);
        check("R1 status", rv, 32'h2);
        check("R1 irq", 32'(irq_o), 32'h0);
        check("R1 baud", 32'(baud_div_o), 32'h0);
        check("R1 tx_valid", 32'(eng_tx_valid), 32'h0);
        check("R11 ready/err", {30'b0, pready, pslverr}, 32'h2);
    endtask

    task automatic t_tx_order();
        apb_write(8'h08, 32'h123456AA);
        check("R2 tx_data", 32'(eng_tx_data), 32'hAA);
        apb_read(8'h04, rv);
        check("R2 tx level", rv, 32'h0000_0102);
        apb_write(8'h08, 32'h55);
        eng_pop();
        check("R3 next byte", 32'(eng_tx_data), 32'h55);
        eng_pop();
        check("R3 drained", 32'(eng_tx_valid), 32'h0);
    endtask

    task automatic t_full_ovf();
        for (int i = 0; i < 16; i++) apb_write(8'h08, 32'(i * 3 + 1));
        apb_read(8'h04, rv);
        check("R4 full status", rv, 32'h0000_1003);
        apb_write(8'h08, 32'hEE);
        apb_read(8'h04, rv);
        check("R5 overflow status", rv, 32'h0000_100B);
        for (int i = 0; i < 16; i++) begin
            check("R5 R3 drain order", 32'(eng_tx_data), 32'(i * 3 + 1));
            eng_pop();
        end
        check("R5 extra byte discarded", 32'(eng_tx_valid), 32'h0);
        apb_read(8'h04, rv);
        check("R5 sticky after drain", rv, 32'h0000_000A);
        apb_write(8'h04, 32'h8);
        apb_read(8'h04, rv);
        check("R5 cleared", rv, 32'h2);
    endtask

    task automatic t_rx();
        eng_push(8'hBB);
        eng_push(8'hC1);
        eng_busy = 1;
        apb_read(8'h04, rv);
        check("R8 status layout", rv, 32'h0002_0004);
        eng_busy = 0;
        apb_read(8'h0C, rv);
        check("R6 first byte", rv, 32'hBB);
        apb_read(8'h0C, rv);
        check("R6 second byte", rv, 32'hC1);
        apb_read(8'h0C, rv);
        check("R7 empty read", rv, 32'h0);
        apb_read(8'h04, rv);
        check("R7 level unchanged", rv, 32'h2);
    endtask

    task automatic t_rx_full();
        for (int j = 0; j < 17; j++) eng_push(8'(j + 8'h40));
        apb_read(8'h04, rv);
        check("R12 rx level", rv, 32'h0010_0000);
        for (int j = 0; j < 16; j++) begin
            apb_read(8'h0C, rv);
            check("R12 rx contents", rv, 32'(j + 8'h40));
        end
        apb_read(8'h04, rv);
        check("R12 rx empty after", rv, 32'h2);
    endtask

    task automatic t_irq();
        check("R9 irq off when disabled", 32'(irq_o), 32'h0);
        apb_write(8'h10, 32'h1);
        check("R9 irq on", 32'(irq_o), 32'h1);
        apb_read(8'h10, rv);
        check("R9 enable readback", rv, 32'h1);
        apb_write(8'h08, 32'h77);
        check("R9 irq falls on write", 32'(irq_o), 32'h0);
        eng_pop();
        check("R9 irq back when empty", 32'(irq_o), 32'h1);
        apb_write(8'h10, 32'h0);
        check("R9 irq falls on disable", 32'(irq_o), 32'h0);
    endtask

    task automatic t_baud();
        apb_write(8'h14, 32'hABCD1234);
        check("R10 baud out", 32'(baud_div_o), 32'h1234);
        apb_read(8'h14, rv);
        check("R10 baud readback", rv, 32'h1234);
        check("R11 ready/err", {30'b0, pready, pslverr}, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1;
        t_reset();
        t_tx_order();
        t_full_ovf();
        t_rx();
        t_rx_full();
        t_irq();
        t_baud();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule